// File: doc/BRIEF.md
# One-Wire Network Address Phase Controller

This block runs the address stage of a one-wire slave. It sits between a bit-level slot engine and the function-command layer. The slot engine reports every bus reset and every time slot it completes. Ahead of each slot, the block tells the slot engine whether to drive a data bit and which value to drive. After each bus reset the block takes in an 8-bit command code. It then answers one of four address procedures: it reports its identifier, compares an identifier the master sends, selects itself at once, or takes part in the bit-wise search arbitration. When the procedure succeeds it raises a selection flag for the function layer. When the procedure fails, or the code is unknown, it stays silent until the next bus reset.

The 64-bit identifier is made of three parts. The low byte is a family code fixed by parameter. The middle 48 bits are a serial number taken from an input. The top byte is a CRC-8 that the block computes serially after its own reset.

Top module: `owid_rom_ctrl`

## Requirements
- R1: After `rst`, and before any bus reset, `selected` and `tx_en` are 0 and completed slots cause no response.
- R2: The identifier's top byte is a CRC over the 56 bits {serial, family}. It is shifted in least significant bit first from an all-zero start, with polynomial x^8+x^5+x^4+1 (reflected constant 8Ch). It is ready within 64 clocks after `rst` falls.
- R3: After a bus reset, the next 8 slots form the command code, least significant bit first.
- R4: Code 33h makes the next 64 slots drive the identifier least significant bit first: bits 0-7 are the family code (default 09h), bits 8-55 are the serial and bits 56-63 are the CRC. `selected` then rises.
- R5: Code 55h makes the block read 64 slots and compare each one with the matching identifier bit. If all 64 are equal, `selected` rises. On the first difference the block stays deselected and ignores all slots until a bus reset.
- R6: Code CCh raises `selected` right after the eighth command slot, with no address transfer.
- R7: Code F0h runs 64 triplets. For each bit the block drives the identifier bit, then its complement, then reads the master's chosen bit. If the chosen bit differs from its own bit, the block drops out until a bus reset. After all 64 triplets it is selected.
- R8: Any other code leaves the block deselected, with `tx_en` at 0, until the next bus reset.
- R9: A bus reset aborts any procedure, clears `selected` within 2 clocks, and restarts command reception.
- R10: `tx_en`/`tx_bit` for the next slot are valid 2 clocks after the strobe of the previous slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_serial | input | SERIAL_W | Serial number, stable from reset onward |
| wire_reset | input | 1 | One-clock pulse: reset pulse seen on the wire |
| slot_stb | input | 1 | One-clock pulse: a time slot completed |
| slot_val | input | 1 | Line value sampled in that slot |
| tx_en | output | 1 | Drive a data bit in the next slot |
| tx_bit | output | 1 | Value to drive when `tx_en` is 1 |
| selected | output | 1 | Address phase succeeded; function layer may proceed |

## Verification
The bench runs a set of serial patterns: all zeros, all ones, a sparse value and an alternating value. For each one it reads the identifier and checks it against a CRC computed in the bench, which separates a wrong polynomial, wrong bit order or wrong field placement. For match, it flips every one of the 64 bits in turn, which shows whether a mismatch at any position, including the first and last, is caught. For search, it makes a full pass and also drops out at the edges and in the middle, which separates complement and read phases that are misaligned. It also sweeps all 256 command codes, which tells the four valid codes apart from every unknown one.

// File: rtl/owid_pkg.sv
package owid_pkg;

  typedef enum logic [2:0] {
    ST_PARK,
    ST_CMD,
    ST_READ,
    ST_MATCH,
    ST_SEARCH,
    ST_SEL
  } owid_state_e;

  localparam int CMD_W = 8;

  localparam logic [CMD_W-1:0] CMD_READ   = 8'h33;
  localparam logic [CMD_W-1:0] CMD_MATCH  = 8'h55;
  localparam logic [CMD_W-1:0] CMD_SKIP   = 8'hCC;
  localparam logic [CMD_W-1:0] CMD_SEARCH = 8'hF0;

  // x^8+x^5+x^4+1 in shift-right (reflected) form
  localparam logic [7:0] CRC_REFL = 8'h8C;

  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic b);
    logic fb;
    fb = c[0] ^ b;
    return (c >> 1) ^ (fb ? CRC_REFL : 8'h00);
  endfunction

endpackage

// File: rtl/owid_crc_gen.sv
module owid_crc_gen #(
  parameter int DATA_W = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] data_in,
  output logic [7:0]        crc_out,
  output logic              done
);
  import owid_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      crc_out <= '0;
      done    <= 1'b0;
    end else if (!done) begin
      crc_out <= crc8_step(crc_out, data_in[cnt]);
      cnt     <= cnt + 1'b1;
      if (cnt == CNT_LAST) done <= 1'b1;
    end
  end

  AST_CRC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && $stable(crc_out))); // R2

endmodule

// File: rtl/owid_id_store.sv
module owid_id_store #(
  parameter int          SERIAL_W    = 48,
  parameter logic [7:0]  FAMILY_CODE = 8'h09,
  parameter int          ID_W        = 64,
  parameter int          IDX_W       = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SERIAL_W-1:0] serial,
  input  logic [IDX_W-1:0]    bit_sel,
  output logic                id_bit
);
  localparam int BODY_W = SERIAL_W + 8;

  logic [7:0]    crc;
  logic          crc_done;
  logic [ID_W-1:0] id_word;

  owid_crc_gen #(.DATA_W(BODY_W)) u_crc (
    .clk     (clk),
    .rst     (rst),
    .data_in ({serial, FAMILY_CODE}),
    .crc_out (crc),
    .done    (crc_done)
  );

  assign id_word = {crc, serial, FAMILY_CODE};
  assign id_bit  = id_word[bit_sel];

  AST_ID_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
    crc_done |=> crc_done); // R2

endmodule

// File: rtl/owid_cmd_fsm.sv
module owid_cmd_fsm #(
  parameter int ID_W  = 64,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wire_reset,
  input  logic             slot_stb,
  input  logic             slot_val,
  input  logic             id_bit,
  output logic [IDX_W-1:0] bit_sel,
  output logic             tx_en,
  output logic             tx_bit,
  output logic             selected
);
  import owid_pkg::*;

  localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(CMD_W - 1);
  localparam logic [IDX_W-1:0] ID_LAST  = IDX_W'(ID_W - 1);

  owid_state_e      state;
  logic [IDX_W-1:0] idx;
  logic [1:0]       phase;
  logic [CMD_W-1:0] shreg;
  logic [CMD_W-1:0] cmd_word;

  assign bit_sel  = idx;
  assign cmd_word = {slot_val, shreg[CMD_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PARK;
      idx      <= '0;
      phase    <= 2'd0;
      shreg    <= '0;
      tx_en    <= 1'b0;
      tx_bit   <= 1'b0;
      selected <= 1'b0;
    end else begin
      tx_en    <= (state == ST_READ) || (state == ST_SEARCH && phase != 2'd2);
      tx_bit   <= (state == ST_SEARCH && phase == 2'd1) ? ~id_bit : id_bit;
      selected <= (state == ST_SEL);
      if (wire_reset) begin
        state <= ST_CMD;
        idx   <= '0;
        phase <= 2'd0;
      end else if (slot_stb) begin
        case (state)
          ST_CMD: begin
            shreg <= cmd_word;
            if (idx == CMD_LAST) begin
              idx <= '0;
              case (cmd_word)
                CMD_READ:   state <= ST_READ;
                CMD_MATCH:  state <= ST_MATCH;
                CMD_SKIP:   state <= ST_SEL;
                CMD_SEARCH: state <= ST_SEARCH;
                default:    state <= ST_PARK;
              endcase
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_READ: begin
            if (idx == ID_LAST) begin
              state <= ST_SEL;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_MATCH: begin
            if (slot_val != id_bit) begin
              state <= ST_PARK;
            end else if (idx == ID_LAST) begin
              state <= ST_SEL;
              idx   <= '0;
            end else begin
              idx <= idx + 1'b1;
            end
          end
          ST_SEARCH: begin
            if (phase != 2'd2) begin
              phase <= phase + 2'd1;
            end else begin
              phase <= 2'd0;
              if (slot_val != id_bit) begin
                state <= ST_PARK;
              end else if (idx == ID_LAST) begin
                state <= ST_SEL;
                idx   <= '0;
              end else begin
                idx <= idx + 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  AST_CMD_COUNT: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD) |-> (idx < IDX_W'(CMD_W))); // R3
  AST_PARK_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PARK && !wire_reset) |=> (state == ST_PARK)); // R5
  AST_SKIP_NOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_CMD && slot_stb && !wire_reset && idx == CMD_LAST && cmd_word == CMD_SKIP)
      |=> (state == ST_SEL)); // R6
  AST_SEARCH_PHASE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SEARCH) |-> (phase != 2'd3)); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (rst)
    wire_reset |=> (state == ST_CMD && idx == '0)); // R9
  AST_DESELECT: assert property (@(posedge clk) disable iff (rst)
    wire_reset |=> ##1 !selected); // R9
  AST_TX_NOT_SELECTED: assert property (@(posedge clk) disable iff (rst)
    tx_en |-> !selected); // R4

endmodule

// File: rtl/owid_rom_ctrl.sv
module owid_rom_ctrl #(
  parameter int         SERIAL_W    = 48,
  parameter logic [7:0] FAMILY_CODE = 8'h09
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SERIAL_W-1:0] id_serial,
  input  logic                wire_reset,
  input  logic                slot_stb,
  input  logic                slot_val,
  output logic                tx_en,
  output logic                tx_bit,
  output logic                selected
);
  localparam int ID_W  = SERIAL_W + 16;
  localparam int IDX_W = $clog2(ID_W);

  logic [IDX_W-1:0] bit_sel;
  logic             id_bit;

  owid_id_store #(
    .SERIAL_W    (SERIAL_W),
    .FAMILY_CODE (FAMILY_CODE),
    .ID_W        (ID_W),
    .IDX_W       (IDX_W)
  ) u_id (
    .clk     (clk),
    .rst     (rst),
    .serial  (id_serial),
    .bit_sel (bit_sel),
    .id_bit  (id_bit)
  );

  owid_cmd_fsm #(
    .ID_W  (ID_W),
    .IDX_W (IDX_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .wire_reset (wire_reset),
    .slot_stb   (slot_stb),
    .slot_val   (slot_val),
    .id_bit     (id_bit),
    .bit_sel    (bit_sel),
    .tx_en      (tx_en),
    .tx_bit     (tx_bit),
    .selected   (selected)
  );

endmodule

// File: tb/test_owid_rom_ctrl.sv
module test_owid_rom_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [47:0] id_serial = '0;
  logic        wire_reset = 1'b0;
  logic        slot_stb = 1'b0;
  logic        slot_val = 1'b0;
  logic        tx_en, tx_bit, selected;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  owid_rom_ctrl i_owid_rom_ctrl (
    .clk(clk), .rst(rst), .id_serial(id_serial), .wire_reset(wire_reset),
    .slot_stb(slot_stb), .slot_val(slot_val),
    .tx_en(tx_en), .tx_bit(tx_bit), .selected(selected)
  );

  function automatic logic [7:0] ref_crc(input logic [55:0] d);
    logic [7:0] c = 8'h00;
    for (int i = 0; i < 56; i++) begin
      logic mix = c[0] ^ d[i];
      c = {1'b0, c[7:1]};
      if (mix) c = c ^ 8'b1000_1100;
    end
    return c;
  endfunction

  function automatic logic [63:0] ref_id(input logic [47:0] s);
    return {ref_crc({s, 8'h09}), s, 8'h09};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // one slot: master writes mbit; line is wired-AND with the slave drive
  task automatic slot(input logic mbit, output logic line, output logic en);
    @(negedge clk);
    en = tx_en;
    line = tx_en ? (tx_bit & mbit) : mbit;
    slot_val = line;
    slot_stb = 1'b1;
    @(negedge clk);
    slot_stb = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_reset();
    @(negedge clk);
    wire_reset = 1'b1;
    @(negedge clk);
    wire_reset = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic send_code(input logic [7:0] c, output logic any_en);
    logic l, e;
    any_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      slot(c[i], l, e);
      any_en |= e;
    end
  endtask

  task automatic hard_reset(input logic [47:0] s);
    @(negedge clk);
    rst = 1'b1;
    id_serial = s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (80) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    logic [47:0] pats [4];
    logic [63:0] exp_id, got;
    logic l, e, ae, all_en;
    pats[0] = 48'h0000_0000_0000;
    pats[1] = 48'hFFFF_FFFF_FFFF;
    pats[2] = 48'h0000_0001_B81C;
    pats[3] = 48'hA5A5_3C3C_0F0F;

    for (int p = 0; p < 4; p++) begin
      hard_reset(pats[p]);
      exp_id = ref_id(pats[p]);

      // R1: idle after reset, slots ignored before any bus reset
      chk(!selected && !tx_en, "R1 reset state", {tx_en, selected}, 0);
      slot(1'b1, l, e);
      slot(1'b1, l, e);
      chk(!selected && !tx_en && !e, "R1 slots before bus reset", {e, tx_en, selected}, 0);

      // R4 read address, with R10 output timing on the last command bit
      bus_reset();
      for (int i = 0; i < 7; i++) slot(logic'(8'h33 >> i), l, e);
      @(negedge clk);
      slot_val = 1'b0; slot_stb = 1'b1;
      @(negedge clk);
      slot_stb = 1'b0;
      chk(tx_en == 1'b0, "R10 tx_en one clock after strobe", tx_en, 0);
      @(negedge clk);
      chk(tx_en == 1'b1, "R10 tx_en two clocks after strobe", tx_en, 1);
      repeat (2) @(negedge clk);
      all_en = 1'b1;
      for (int i = 0; i < 64; i++) begin
        slot(1'b1, l, e);
        got[i] = l;
        all_en &= e;
      end
      chk(got == exp_id, "R4 identifier", got, exp_id);
      chk(got[63:56] == ref_crc({pats[p], 8'h09}), "R2 crc byte", got[63:56], ref_crc({pats[p], 8'h09}));
      chk(all_en && selected && !tx_en, "R4 driven then selected", {all_en, selected, tx_en}, 3'b110);

      // R6 skip; R9 reset clears selection
      bus_reset();
      send_code(8'hCC, ae);
      chk(selected && !ae, "R6 skip selects", {ae, selected}, 1);
      bus_reset();
      chk(!selected, "R9 bus reset clears selected", selected, 0);

      // R5 match exact
      bus_reset();
      send_code(8'h55, ae);
      ae = 1'b0;
      for (int i = 0; i < 64; i++) begin slot(exp_id[i], l, e); ae |= e; end
      chk(selected && !ae, "R5 match equal", {ae, selected}, 1);

      // R5 mismatch at each position (full sweep on first pattern)
      for (int k = 0; k < 64; k++) begin
        if (p != 0 && k != 0 && k != 31 && k != 63) continue;
        bus_reset();
        send_code(8'h55, ae);
        ae = 1'b0;
        for (int i = 0; i < 64; i++) begin
          slot((i == k) ? ~exp_id[i] : exp_id[i], l, e);
          ae |= e;
        end
        slot(1'b1, l, e);
        ae |= e;
        chk(!selected && !ae, $sformatf("R5 mismatch bit %0d", k), {ae, selected}, 0);
      end

      // R7 full search
      bus_reset();
      send_code(8'hF0, ae);
      all_en = 1'b1;
      got = '0;
      for (int i = 0; i < 64; i++) begin
        logic a, b;
        slot(1'b1, a, e); all_en &= e;
        slot(1'b1, b, e); all_en &= e;
        if (a != exp_id[i] || b != ~exp_id[i]) got[i] = 1'b1;
        slot(exp_id[i], l, e);
        if (e) all_en = 1'b0;
      end
      chk(got == 0 && all_en, "R7 bit and complement", got, 0);
      chk(selected, "R7 search completes", selected, 1);

      // R7 dropout positions
      for (int q = 0; q < 3; q++) begin
        int k = (q == 0) ? 0 : (q == 1) ? 17 : 63;
        bus_reset();
        send_code(8'hF0, ae);
        for (int i = 0; i < k; i++) begin
          slot(1'b1, l, e); slot(1'b1, l, e); slot(exp_id[i], l, e);
        end
        slot(1'b1, l, e); slot(1'b1, l, e); slot(~exp_id[k], l, e);
        ae = 1'b0;
        for (int j = 0; j < 6; j++) begin slot(1'b1, l, e); ae |= e; end
        chk(!selected && !ae, $sformatf("R7 dropout at %0d", k), {ae, selected}, 0);
      end
    end

    // R8 sweep of all codes; R3 order: CCh selects, its bit reverse 33h does not
    for (int c = 0; c < 256; c++) begin
      logic [7:0] code = 8'(c);
      if (code == 8'h33 || code == 8'h55 || code == 8'hF0) continue;
      bus_reset();
      send_code(code, ae);
      if (code == 8'hCC) begin
        chk(selected, "R3 code CCh received LSB first", selected, 1);
      end else begin
        slot(1'b1, l, e); ae |= e;
        slot(1'b1, l, e); ae |= e;
        chk(!selected && !ae, $sformatf("R8 unknown code %02h", code), {ae, selected}, 0);
      end
    end

    finish_up();
  end

endmodule